// File: doc/BRIEF.md
# Mixed Fixed-Priority and Weighted Round-Robin Slave Arbiter

This block sits in front of one slave of a multi-layer AHB interconnect and decides which of ten masters may drive that slave's address phase. Each master raises a request when its address decode hits this slave with a valid transfer, and gets back a one-hot address-ready grant. Masters 0 to 3 hold strict priorities, with master 0 first. Masters 4 to 9 share the lowest tier. Among themselves they are served by weighted round-robin, and each has its own programmable weight.

A grant only moves at an edge where the slave reports ready. Once the granted master opens a burst, the grant stays with it until the slave accepts the final beat, or, for an undefined-length burst, until the master lets go. The block also forwards the owner's transfer type to the slave. When nobody owns the slave it forwards IDLE.

Top module: `mixed_slave_arb`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `gnt_o` is all zero and `htrans_o` is IDLE (2'b00).
- R2: `gnt_o` has at most one bit set, and bit i set means master i owns the slave.
- R3: `gnt_o` changes only after a rising edge at which `hready_i` was high.
- R4: At an arbitration edge, the lowest-numbered requesting master among 0..3 wins, ahead of any request from masters 4..9.
- R5: When none of masters 0..3 request, the winner is the first requesting master among 4..9, searched cyclically from the round-robin pointer (which starts at master 4 after reset).
- R6: The weight field for master 4+k is `wgt_i[5k+4:5k]`, and a value v gives W = v+1. A master may win up to W consecutive arbitrations. After its W-th win the pointer moves to the next master. Winning while the pointer rests elsewhere restarts its count at one.
- R7: Arbitrations won by masters 0..3 leave the round-robin pointer and credit unchanged.
- R8: Transfer types are 0 IDLE, 1 BUSY, 2 NONSEQ and 3 SEQ. Burst codes 2/3 give 4 beats, 4/5 give 8 and 6/7 give 16. An accepted NONSEQ with a fixed-length code keeps the grant until the edge that accepts the last SEQ beat, even against higher-priority requests.
- R9: An accepted NONSEQ with burst code 1 (undefined length) keeps the grant while the owner's request stays high and it does not present IDLE.
- R10: A NONSEQ with burst code 0 (single) releases the grant at the edge that accepts it. With no requests there is no owner. `htrans_o` equals the owner's transfer type, or IDLE when there is no owner.
- R11: Beats are counted only at edges where `hready_i` is high. A stalled edge neither shortens a burst nor moves the grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 10 | Per-master request (slave selected and transfer valid) |
| htrans_i | input | 20 | Per-master transfer type, 2 bits per master, master i at [2i+1:2i] |
| hburst_i | input | 30 | Per-master burst code, 3 bits per master, master i at [3i+2:3i] |
| hready_i | input | 1 | Slave ready; the transfer boundary |
| wgt_i | input | 30 | Weight fields for masters 4..9, 5 bits each |
| gnt_o | output | 10 | One-hot address-ready grant |
| htrans_o | output | 2 | Transfer type forwarded to the slave |

## Verification
A wrong burst count shows at the grant port at the edge where the burst should end. The grant either leaves one beat early, or it stays while a higher-priority master waits. A slipped round-robin pointer or credit shows at the very next arbitration won by the shared tier, as a master that wins once too often or is skipped. Because of this, the bench predicts the owner edge by edge and compares it every cycle. Runs of equal-tier wins with uneven weights, and fixed-priority wins inserted in the middle of a weight run, expose the credit state within a few cycles.

// File: rtl/msarb_pkg.sv
package msarb_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } trans_e;

  // Beat count of a burst code; 0 marks an undefined-length burst.
  function automatic logic [4:0] burst_beats(input logic [2:0] code);
    case (code)
      3'd0:       burst_beats = 5'd1;
      3'd1:       burst_beats = 5'd0;
      3'd2, 3'd3: burst_beats = 5'd4;
      3'd4, 3'd5: burst_beats = 5'd8;
      default:    burst_beats = 5'd16;
    endcase
  endfunction

  // Next position on a ring of n entries.
  function automatic int ring_next(input int pos, input int n);
    ring_next = (pos == n - 1) ? 0 : pos + 1;
  endfunction

endpackage

// File: rtl/fix_pick.sv
module fix_pick #(
  parameter int N  = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/wrr_pick.sv
module wrr_pick
  import msarb_pkg::*;
#(
  parameter int NW = 6,
  parameter int WW = 5,
  localparam int IW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NW-1:0]   req,
  input  logic [NW*WW-1:0] wgt,
  input  logic            take,
  output logic            any,
  output logic [IW-1:0]   idx
);
  logic [IW-1:0] ptr_q;
  logic [WW-1:0] cred_q;
  logic [WW-1:0] sel_w;
  logic [WW:0]   used_nx;
  logic [WW:0]   limit;
  logic          advance;
  logic [IW-1:0] ptr_nx;
  logic [WW-1:0] cred_nx;

  // cyclic search starting at the pointer
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int k = NW - 1; k >= 0; k--) begin
      int j;
      j = (int'(ptr_q) + k) % NW;
      if (req[j]) begin
        any = 1'b1;
        idx = IW'(j);
      end
    end
  end

  // credit arithmetic for the winner
  always_comb begin
    sel_w   = wgt[int'(idx)*WW +: WW];
    limit   = {1'b0, sel_w} + 1'b1;
    used_nx = ((idx == ptr_q) ? {1'b0, cred_q} : '0) + 1'b1;
    advance = (used_nx >= limit);
    ptr_nx  = advance ? IW'(ring_next(int'(idx), NW)) : idx;
    cred_nx = advance ? '0 : used_nx[WW-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      cred_q <= '0;
    end else if (take && any) begin
      ptr_q  <= ptr_nx;
      cred_q <= cred_nx;
    end
  end

  // R5
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) < NW);

  // R7
  wrr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(ptr_q) && $stable(cred_q));

  // R6
  unit_weight_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && any && sel_w == '0) |=> ptr_q != $past(idx));
endmodule

// File: rtl/burst_hold.sv
module burst_hold
  import msarb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hready,
  input  logic       own_vld,
  input  logic       own_req,
  input  logic [1:0] own_tr,
  input  logic [2:0] own_bu,
  output logic       hold,
  output logic       beat_acc
);
  logic [4:0] left_q, left_nx;
  logic       open_q, open_nx;
  logic [4:0] beats;

  assign beats    = burst_beats(own_bu);
  assign beat_acc = own_vld && hready && own_tr[1];

  always_comb begin
    left_nx = left_q;
    open_nx = open_q;
    if (!own_vld) begin
      left_nx = '0;
      open_nx = 1'b0;
    end else begin
      unique case (trans_e'(own_tr))
        TR_NONSEQ: begin
          open_nx = (beats == 5'd0);
          left_nx = (beats == 5'd0) ? 5'd0 : beats - 5'd1;
        end
        TR_SEQ:  if (left_q != 5'd0) left_nx = left_q - 5'd1;
        TR_IDLE: begin
          left_nx = '0;
          open_nx = 1'b0;
        end
        default: ;
      endcase
      if (!own_req) open_nx = 1'b0;
    end
  end

  assign hold = own_vld && ((left_nx != 5'd0) || open_nx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      left_q <= '0;
      open_q <= 1'b0;
    end else if (hready) begin
      left_q <= hold ? left_nx : 5'd0;
      open_q <= hold ? open_nx : 1'b0;
    end
  end

  // R11
  stall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hready |=> $stable(left_q) && $stable(open_q));

  // R8
  no_orphan_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left_q != 5'd0) |-> own_vld);
endmodule

// File: rtl/mixed_slave_arb.sv
module mixed_slave_arb
  import msarb_pkg::*;
#(
  parameter int NUM_FIX = 4,
  parameter int NUM_WRR = 6,
  parameter int WGT_W   = 5,
  localparam int NM     = NUM_FIX + NUM_WRR,
  localparam int IDW    = $clog2(NM),
  localparam int FIW    = (NUM_FIX > 1) ? $clog2(NUM_FIX) : 1,
  localparam int WIW    = (NUM_WRR > 1) ? $clog2(NUM_WRR) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NM-1:0]            req_i,
  input  logic [NM*2-1:0]          htrans_i,
  input  logic [NM*3-1:0]          hburst_i,
  input  logic                     hready_i,
  input  logic [NUM_WRR*WGT_W-1:0] wgt_i,
  output logic [NM-1:0]            gnt_o,
  output logic [1:0]               htrans_o
);
  logic           own_vld;
  logic [IDW-1:0] own_id;
  logic           own_req;
  logic [1:0]     own_tr;
  logic [2:0]     own_bu;
  logic           hold;
  logic           beat_acc;
  logic           arb_evt;
  logic           fix_any, wrr_any, wrr_take;
  logic [FIW-1:0] fix_idx;
  logic [WIW-1:0] wrr_idx;
  logic           win_vld;
  logic [IDW-1:0] win_id;

  assign own_req = req_i[own_id];
  assign own_tr  = htrans_i[int'(own_id)*2 +: 2];
  assign own_bu  = hburst_i[int'(own_id)*3 +: 3];

  burst_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .hready   (hready_i),
    .own_vld  (own_vld),
    .own_req  (own_req),
    .own_tr   (own_tr),
    .own_bu   (own_bu),
    .hold     (hold),
    .beat_acc (beat_acc)
  );

  fix_pick #(.N(NUM_FIX)) u_fix (
    .req (req_i[NUM_FIX-1:0]),
    .any (fix_any),
    .idx (fix_idx)
  );

  assign arb_evt  = hready_i && !hold;
  assign wrr_take = arb_evt && !fix_any;

  wrr_pick #(.NW(NUM_WRR), .WW(WGT_W)) u_wrr (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (req_i[NM-1:NUM_FIX]),
    .wgt   (wgt_i),
    .take  (wrr_take),
    .any   (wrr_any),
    .idx   (wrr_idx)
  );

  assign win_vld = fix_any || wrr_any;
  assign win_id  = fix_any ? IDW'(fix_idx) : IDW'(NUM_FIX) + IDW'(wrr_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_vld <= 1'b0;
      own_id  <= '0;
    end else if (arb_evt) begin
      own_vld <= win_vld;
      own_id  <= win_vld ? win_id : '0;
    end
  end

  generate
    for (genvar g = 0; g < NM; g++) begin : g_gnt
      assign gnt_o[g] = own_vld && (int'(own_id) == g);
    end
  endgenerate

  assign htrans_o = own_vld ? own_tr : TR_IDLE;

  // R2
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_o));

  // R3
  gnt_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hready_i |=> $stable(gnt_o));

  // R4
  fix_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_evt && |req_i[NUM_FIX-1:0]) |=> |gnt_o[NUM_FIX-1:0]);

  // R8
  burst_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && hready_i) |=> $stable(gnt_o));

  // R10
  idle_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_o == '0) |-> (htrans_o == 2'b00));

  // R10
  served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_evt && |req_i) |=> (gnt_o != '0));
endmodule

// File: tb/mixed_slave_arb_bench.sv
module mixed_slave_arb_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  req = '0;
  logic [1:0]  htr = 2'd0;
  logic [2:0]  hbu = 3'd0;
  logic        hrd = 1'b1;
  logic [29:0] wgt;
  logic [9:0]  gnt_o;
  logic [1:0]  htrans_o;

  int tests = 0;
  int fails = 0;

  // weights: master4 v=1 (W=2), master6 v=2 (W=3), others v=0 (W=1)
  int wv [6] = '{1, 0, 2, 0, 0, 0};
  assign wgt = {5'd0, 5'd0, 5'd0, 5'd2, 5'd0, 5'd1};

  always #2 clk = ~clk;

  mixed_slave_arb u_mixed_slave_arb (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_i    (req),
    .htrans_i ({10{htr}}),
    .hburst_i ({10{hbu}}),
    .hready_i (hrd),
    .wgt_i    (wgt),
    .gnt_o    (gnt_o),
    .htrans_o (htrans_o)
  );

  typedef struct {
    int    own;
    string tag;
  } exp_t;
  exp_t sbq[$];

  // reference state
  int m_own = -1, m_left = 0, m_ptr = 0, m_cred = 0;
  bit m_open = 0;

  task automatic model_edge();
    bit keep;
    if (!hrd) return;
    if (m_own >= 0) begin
      if (htr == 2'd2) begin
        m_open = (hbu == 3'd1);
        if (hbu <= 3'd1) m_left = 0;
        else if (hbu <= 3'd3) m_left = 3;
        else if (hbu <= 3'd5) m_left = 7;
        else m_left = 15;
      end else if (htr == 2'd3) begin
        if (m_left > 0) m_left--;
      end else if (htr == 2'd0) begin
        m_left = 0;
        m_open = 0;
      end
      if (!req[m_own]) m_open = 0;
    end
    keep = (m_own >= 0) && (m_left > 0 || m_open);
    if (keep) return;
    m_left = 0;
    m_open = 0;
    m_own  = -1;
    for (int i = 0; i < 4; i++) if (req[i] && m_own < 0) m_own = i;
    if (m_own >= 0) return;
    for (int k = 0; k < 6; k++) begin
      int j;
      j = (m_ptr + k) % 6;
      if (req[4+j] && m_own < 0) begin
        m_own  = 4 + j;
        m_cred = (j == m_ptr) ? m_cred + 1 : 1;
        if (m_cred >= wv[j] + 1) begin
          m_ptr  = (j + 1) % 6;
          m_cred = 0;
        end else m_ptr = j;
      end
    end
  endtask

  task automatic cyc(input logic [9:0] rq, input logic [1:0] tr,
                     input logic [2:0] bu, input logic hr, input string tag);
    @(negedge clk);
    req = rq;
    htr = tr;
    hbu = bu;
    hrd = hr;
    model_edge();
    sbq.push_back('{m_own, tag});
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor: compare after every edge that has an expectation
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        logic [9:0] eg;
        int et;
        e  = sbq.pop_front();
        eg = (e.own >= 0) ? (10'd1 << e.own) : 10'd0;
        et = (e.own >= 0) ? int'(htr) : 0;
        check(gnt_o == eg, e.tag, int'(gnt_o), int'(eg));
        check(int'(htrans_o) == et, {e.tag, " htrans"}, int'(htrans_o), et);
        check($countones(gnt_o) <= 1, "R2 onehot", $countones(gnt_o), 1);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    req = 10'h3FF;
    htr = 2'd2;
    @(negedge clk);
    check(gnt_o == 10'd0, "R1 reset gnt", int'(gnt_o), 0);
    check(htrans_o == 2'd0, "R1 reset htrans", int'(htrans_o), 0);
    req = '0;
    htr = 2'd0;
    rst_n = 1'b1;
    cyc(10'h000, 2'd0, 3'd0, 1'b1, "R1 idle");
    cyc(10'h000, 2'd0, 3'd0, 1'b1, "R10 no request");
    // R4 fixed priority over shared tier
    cyc(10'b0000100101, 2'd2, 3'd0, 1'b1, "R4 m0 wins");
    cyc(10'b0010000110, 2'd2, 3'd0, 1'b1, "R4 m1 wins");
    cyc(10'b1000001000, 2'd2, 3'd0, 1'b1, "R4 m3 over m9");
    // R5 / R6 weighted run over all shared masters
    for (int n = 0; n < 4; n++) cyc(10'b1111110000, 2'd2, 3'd0, 1'b1, "R5 rr order");
    for (int n = 0; n < 8; n++) cyc(10'b1111110000, 2'd2, 3'd0, 1'b1, "R6 weight run");
    // R7 fixed wins inserted mid-run
    cyc(10'b1111110100, 2'd2, 3'd0, 1'b1, "R7 fixed cuts in");
    cyc(10'b1111110001, 2'd2, 3'd0, 1'b1, "R7 fixed again");
    for (int n = 0; n < 5; n++) cyc(10'b1111110000, 2'd2, 3'd0, 1'b1, "R7 resume");
    // R5 sparse requests
    cyc(10'b0100100000, 2'd2, 3'd0, 1'b1, "R5 sparse");
    cyc(10'b0100100000, 2'd2, 3'd0, 1'b1, "R5 sparse");
    cyc(10'b0100100000, 2'd2, 3'd0, 1'b1, "R5 sparse");
    // R3 stall keeps grant even with higher request
    cyc(10'b0000000001, 2'd2, 3'd0, 1'b0, "R3 stall");
    cyc(10'b0000000001, 2'd2, 3'd0, 1'b0, "R3 stall");
    // R8 fixed-length burst by m1, m0 waiting
    cyc(10'b0000000010, 2'd2, 3'd0, 1'b1, "R8 m1 granted");
    cyc(10'b0000000011, 2'd2, 3'd3, 1'b1, "R8 burst start");
    cyc(10'b0000000011, 2'd3, 3'd3, 1'b0, "R11 stalled beat");
    cyc(10'b0000000011, 2'd3, 3'd3, 1'b0, "R11 stalled beat");
    cyc(10'b0000000011, 2'd3, 3'd3, 1'b1, "R8 beat 2");
    cyc(10'b0000000011, 2'd1, 3'd3, 1'b1, "R8 busy");
    cyc(10'b0000000011, 2'd3, 3'd3, 1'b1, "R8 beat 3");
    cyc(10'b0000000011, 2'd3, 3'd3, 1'b1, "R8 final beat");
    // R9 undefined-length burst by m5
    cyc(10'b0000100000, 2'd2, 3'd0, 1'b1, "R9 m5 granted");
    cyc(10'b0000100001, 2'd2, 3'd1, 1'b1, "R9 open");
    for (int n = 0; n < 3; n++) cyc(10'b0000100001, 2'd3, 3'd1, 1'b1, "R9 hold");
    cyc(10'b0000000001, 2'd3, 3'd1, 1'b1, "R9 release");
    // R10 singles and idle
    cyc(10'b0000001100, 2'd2, 3'd0, 1'b1, "R10 single");
    cyc(10'b0000001100, 2'd2, 3'd0, 1'b1, "R10 single");
    cyc(10'b0000001000, 2'd2, 3'd0, 1'b1, "R10 single");
    cyc(10'b0000000000, 2'd0, 3'd0, 1'b1, "R10 idle");
    cyc(10'b0000000000, 2'd0, 3'd0, 1'b1, "R10 idle");
    repeat (3) @(posedge clk);
    #1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule